// File: doc/BRIEF.md
# Single-Cycle Bit Search Unit

This block finds where a pattern starts in a 32-bit word by scanning from the most significant bit down toward bit 0. An operand is written together with a search kind. One clock later the block presents how many bits it skipped before the match, along with a flag that marks an empty search. There are three search kinds:

- the first set bit;
- the first clear bit;
- the first bit whose value differs from the top bit, called the change point.

A typical use is normalisation, where the redundant sign bits are the change-point result minus one. Another is priority selection over a request word.

The result register keeps its value until the next write. A new write can be issued on every cycle, and each write produces a fresh result on the following cycle.

Top module: `bit_scan_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `res_pos` = 32 and `res_none` = 1. Reset takes priority over a write in the same cycle.
- R2: Mode `2'b01` (first set bit): `res_pos` is 31 minus the index of the highest bit that is 1. Bit 31 set gives 0, and only bit 0 set gives 31.
- R3: Mode `2'b00` (first clear bit): `res_pos` is 31 minus the index of the highest bit that is 0.
- R4: Mode `2'b10` (change point): `res_pos` is 31 minus the index of the highest bit whose value differs from bit 31. For example, `0x40000000` gives 1 and `0xFFFF0000` gives 16.
- R5: Mode `2'b11` behaves exactly like mode `2'b10`.
- R6: When no bit matches, `res_pos` is 32 and `res_none` is 1. Otherwise `res_none` is 0. In change mode the search matches nothing when all 32 bits are equal.
- R7: A write (`wr_en` high at a rising edge) updates the outputs at that edge, so the result is visible one clock after the operand is presented. Without a write, the outputs hold their value whatever `wr_data` and `wr_mode` carry.
- R8: `res_pos` never exceeds 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Loads the operand and mode and starts a search |
| wr_data | input | 32 | Operand word |
| wr_mode | input | 2 | Search kind: 00 first zero, 01 first one, 10/11 change point |
| res_pos | output | 6 | Bits skipped from the MSB before the match, or 32 when there is none |
| res_none | output | 1 | High when the last search found no matching bit |

## Verification
The checker assumes that `wr_en`, `wr_mode` and `wr_data` are known (free of X) at every rising edge after reset, and that reset is held for at least one edge before any write. The hit-bit properties rely on the checker's own copy of the last written operand, so they hold only when that operand was captured at the same edge as the result. The bench changes inputs only on falling edges and keeps `wr_en` low between directed writes. It drives garbage data and modes while `wr_en` is low to show that nothing else can reach the result register.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [1:0] {
    SRCH_ZERO = 2'b00,
    SRCH_ONE  = 2'b01,
    SRCH_CHG  = 2'b10,
    SRCH_RSV  = 2'b11
  } srch_mode_e;
endpackage

// File: rtl/bscan_prep.sv
// Turns operand and search kind into a vector whose highest set bit is the match.
module bscan_prep
  import bscan_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] op,
  input  logic [1:0]        mode,
  output logic [DATA_W-1:0] vec
);
  always_comb begin
    case (srch_mode_e'(mode))
      SRCH_ZERO: vec = ~op;
      SRCH_ONE:  vec = op;
      // change point: compare each bit with the top bit; the top bit itself drops out
      default:   vec = op ^ {DATA_W{op[DATA_W-1]}};
    endcase
  end
endmodule

// File: rtl/bscan_lzc.sv
// Grouped leading-one counter: per-group priority encoders, then a group select.
module bscan_lzc #(
  parameter int DATA_W = 32,
  parameter int GRP_W  = 8,
  localparam int CNT_W = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] vec,
  output logic [CNT_W-1:0]  cnt,
  output logic              none
);
  localparam int NGRP = DATA_W / GRP_W;
  localparam int GW   = $clog2(GRP_W);

  logic [NGRP-1:0] grp_any;
  logic [GW-1:0]   grp_cnt [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GRP_W-1:0] bits;
    logic [GW-1:0]    lc;
    assign bits = vec[g*GRP_W +: GRP_W];
    always_comb begin
      lc = '0;
      for (int i = 0; i < GRP_W; i++) begin
        if (bits[i]) lc = GW'(GRP_W - 1 - i);
      end
    end
    assign grp_any[g] = |bits;
    assign grp_cnt[g] = lc;
  end

  always_comb begin
    cnt  = CNT_W'(DATA_W);
    none = 1'b1;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_any[g]) begin
        cnt  = CNT_W'((NGRP - 1 - g) * GRP_W) + CNT_W'(grp_cnt[g]);
        none = 1'b0;
      end
    end
  end
endmodule

// File: rtl/bit_scan_unit.sv
module bit_scan_unit #(
  parameter int DATA_W = 32,
  parameter int GRP_W  = 8,
  localparam int CNT_W = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        wr_mode,
  output logic [CNT_W-1:0]  res_pos,
  output logic              res_none
);
  logic [DATA_W-1:0] srch_vec;
  logic [CNT_W-1:0]  cnt_nxt;
  logic              none_nxt;

  bscan_prep #(.DATA_W(DATA_W)) u_prep (
    .op   (wr_data),
    .mode (wr_mode),
    .vec  (srch_vec)
  );

  bscan_lzc #(.DATA_W(DATA_W), .GRP_W(GRP_W)) u_lzc (
    .vec  (srch_vec),
    .cnt  (cnt_nxt),
    .none (none_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_pos  <= CNT_W'(DATA_W);
      res_none <= 1'b1;
    end else if (wr_en) begin
      res_pos  <= cnt_nxt;
      res_none <= none_nxt;
    end
  end
endmodule

// File: rtl/bit_scan_unit_chk.sv
module bit_scan_unit_chk #(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W) + 1,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [1:0]        wr_mode,
  input logic [CNT_W-1:0]  res_pos,
  input logic              res_none
);
  logic [DATA_W-1:0] last_data;
  logic [1:0]        last_mode;
  logic              last_wr;
  logic [IDX_W-1:0]  hit_idx;
  logic              hit_bit;

  always_ff @(posedge clk) begin
    last_wr <= wr_en & ~rst;
    if (wr_en) begin
      last_data <= wr_data;
      last_mode <= wr_mode;
    end
  end

  assign hit_idx = IDX_W'(DATA_W - 1) - res_pos[IDX_W-1:0];
  assign hit_bit = last_data[hit_idx];

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (res_pos == CNT_W'(DATA_W)) && res_none); // R1
  AST_ONE_HIT:  assert property (@(posedge clk) disable iff (rst) (last_wr && last_mode == 2'b01 && !res_none) |-> hit_bit); // R2
  AST_ZERO_HIT: assert property (@(posedge clk) disable iff (rst) (last_wr && last_mode == 2'b00 && !res_none) |-> !hit_bit); // R3
  AST_CHG_HIT:  assert property (@(posedge clk) disable iff (rst) (last_wr && last_mode == 2'b10 && !res_none) |-> (hit_bit != last_data[DATA_W-1])); // R4
  AST_RSV_HIT:  assert property (@(posedge clk) disable iff (rst) (last_wr && last_mode == 2'b11 && !res_none) |-> (hit_bit != last_data[DATA_W-1])); // R5
  AST_NONE_FLAG: assert property (@(posedge clk) disable iff (rst) res_none == (res_pos == CNT_W'(DATA_W))); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (rst) (!$past(wr_en) && !$past(rst)) |-> ($stable(res_pos) && $stable(res_none))); // R7
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst) res_pos <= CNT_W'(DATA_W)); // R8
endmodule

bind bit_scan_unit bit_scan_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_mode(wr_mode),
  .res_pos(res_pos), .res_none(res_none)
);

// File: tb/bit_scan_unit_test.sv
`timescale 1ns/1ps
module bit_scan_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  wr_mode = '0;
  logic [5:0]  res_pos;
  logic        res_none;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bit_scan_unit uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .wr_mode(wr_mode), .res_pos(res_pos), .res_none(res_none)
  );

  // {mode, operand, expected position}; the empty flag is expected when position is 32
  localparam int NV = 17;
  localparam logic [39:0] VEC [NV] = '{
    {2'b01, 32'h8000_0000, 6'd0},   // R2
    {2'b01, 32'h0000_0001, 6'd31},  // R2
    {2'b01, 32'h0001_0000, 6'd15},  // R2
    {2'b01, 32'h0000_FFFF, 6'd16},  // R2
    {2'b01, 32'h0000_0000, 6'd32},  // R6
    {2'b00, 32'hFFFF_FFFF, 6'd32},  // R6
    {2'b00, 32'h7FFF_FFFF, 6'd0},   // R3
    {2'b00, 32'hFFFE_FFFF, 6'd15},  // R3
    {2'b00, 32'hFFFF_FFFE, 6'd31},  // R3
    {2'b10, 32'h0000_0000, 6'd32},  // R6
    {2'b10, 32'hFFFF_FFFF, 6'd32},  // R6
    {2'b10, 32'h4000_0000, 6'd1},   // R4
    {2'b10, 32'hFFFF_0000, 6'd16},  // R4
    {2'b10, 32'h0000_0001, 6'd31},  // R4
    {2'b10, 32'h8000_0000, 6'd1},   // R4
    {2'b11, 32'hC000_0000, 6'd2},   // R5
    {2'b11, 32'h8000_0001, 6'd1}    // R5
  };

  task automatic check(string req, logic [5:0] exp_pos);
    logic exp_none;
    exp_none = (exp_pos == 6'd32);
    checks++;
    if (res_pos !== exp_pos || res_none !== exp_none) begin
      errors++;
      $display("FAIL %s: pos=%0d none=%0b expected pos=%0d none=%0b",
               req, res_pos, res_none, exp_pos, exp_none);
    end
  endtask

  task automatic write_op(logic [1:0] m, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_mode = m; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 6'd32);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      write_op(VEC[i][39:38], VEC[i][37:6]);
      check($sformatf("R2-6 vec%0d", i), VEC[i][5:0]);
    end

    // R7: inputs change without a write; result must hold
    write_op(2'b01, 32'h0010_0000);
    check("R7 load", 6'd11);
    @(negedge clk);
    wr_data = 32'hFFFF_FFFF; wr_mode = 2'b00;
    repeat (3) @(negedge clk);
    check("R7 hold", 6'd11);

    // R7: back-to-back writes, each result one clock later
    @(negedge clk);
    wr_en = 1'b1; wr_mode = 2'b01; wr_data = 32'h0000_0100;
    @(negedge clk);
    check("R7 b2b first", 6'd23);
    wr_mode = 2'b10; wr_data = 32'hF000_0000;
    @(negedge clk);
    wr_en = 1'b0;
    check("R7 b2b second", 6'd4);

    // R5 vs R4 on the same operand
    write_op(2'b11, 32'hFFFF_0000);
    check("R5 reserved mode", 6'd16);

    // R1: reset wins over a simultaneous write
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; wr_mode = 2'b01; wr_data = 32'h8000_0000;
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
    check("R1 reset over write", 6'd32);

    // R8 / R6 after reset: an empty search stays at the top limit
    write_op(2'b00, 32'hFFFF_FFFF);
    check("R8 limit", 6'd32);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: pos=%0d none=%0b expected completion", res_pos, res_none);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule